// File: doc/BRIEF.md
# Single-Word SPI Master Core

This block is a host-programmed SPI master. Software reaches it over a plain 32-bit register bus that has an address, a write strobe, a read strobe and write data, and gets read data back on the cycle after the read strobe. Software chooses a chip select and asserts it, and sets the clock polarity, clock phase, bit order and word size. Each write to the transmit register sends one 8-bit or 16-bit word. When the word is done, a completion flag in the cause register goes high and the received word can be read from the receive register. Software clears the flag by writing zero to it before it starts the next word.

The serial clock does not run on its own. An external divider supplies `sck_en`, a one-cycle pulse, and each pulse moves SCK by one edge. A field in the timing register sets how many core cycles after the capturing SCK edge MISO is registered. Choosing the later point gives slow slaves more time when SCK runs at a high ratio of the core clock.

Top module: `spi_word_master`

## Requirements
- R1: After reset all eight chip-select outputs are high, the cause register (0x10) reads 0, the control register (0x00) reads 0 and the timing register (0x18) reads 0x40, which is sample-point value 1 in bits [7:6].
- R2: Chip-select output k is low only when control bit 0 is 1 and control bits [4:2] equal k. At most one output is low at any time.
- R3: Configuration bit 11 sets the SCK idle level. Configuration bit 12 selects the capture edge. When it is 0, MISO is captured on the first (leading) edge of each bit and MOSI changes on the trailing edge. When it is 1, MOSI changes on the leading edge and MISO is captured on the trailing edge.
- R4: Configuration bit 13 = 1 puts the transmit word on the wire LSB first, and bit 14 = 1 assembles the received word LSB first. When a bit is 0, that direction is MSB first.
- R5: Configuration bit 5 = 1 selects 16-bit words. When it is 0, only data-out bits [7:0] are sent and data-in bits [15:8] read 0.
- R6: A write to data-out (0x08) while idle starts a word. SCK moves one edge per cycle that has `sck_en` high, for exactly 2N edges with N the word size, and ends at its idle level. MOSI changes only on SCK edges.
- R7: Control bit 1 reads 1 while a word is in progress. When the word ends, the cause register reads 1 and data-in (0x0C) holds the received word.
- R8: A write of 0 to the cause register clears the flag. A write of any nonzero value leaves the flag unchanged.
- R9: A write to data-out while a word is in progress is ignored. The word on the wire, the edge count and the data-out readback keep their values.
- R10: Timing bits [7:6] = 2 register MISO two core cycles after the capture edge. The values 0, 1 and 3 register it one cycle after the capture edge.
- R11: Control bits, configuration bits 5 and 11 to 14, and timing bits [7:6] read back as written. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| sck_en | input | 1 | One-cycle pulse that allows the next SCK edge |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 8 | Active-low chip selects |

## Verification
The bench runs all four clock modes, both word sizes and every mix of bit orders. For each word it checks the bits seen on MOSI at the capture edges and the word rebuilt from MISO. A design with the capture and launch edges swapped would read every word shifted by one bit. A design that mixed up the two order bits would reverse only one direction. To test the sample-point delay, the slave model drives one value on MISO in the first cycle after each capture edge and the inverted value afterwards, so delay 1 and delay 2 return complementary words. A design that ignored the field, or decoded 3 as late, gives the wrong word. Writing data-out again during a word, and writing a nonzero value to the cause register, both have to leave no trace. A design that restarted on the second write would send the wrong bits or too many edges.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] A_CFG    = 5'h04;
  localparam logic [ADDR_W-1:0] A_DOUT   = 5'h08;
  localparam logic [ADDR_W-1:0] A_DIN    = 5'h0C;
  localparam logic [ADDR_W-1:0] A_CAUSE  = 5'h10;
  localparam logic [ADDR_W-1:0] A_TIMING = 5'h18;

  // per-word settings, captured when a word starts
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic tx_lsb;
    logic rx_lsb;
    logic wide;
    logic late;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_word_regs.sv
module spi_word_regs
  import spi_word_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic                      busy,
  input  logic                      done,
  input  logic [WORD_W-1:0]         rx_word,
  output logic                      start,
  output logic [WORD_W-1:0]         tx_word,
  output xfer_cfg_t                 cfg,
  output logic                      cause,
  output logic                      cs_on,
  output logic [$clog2(NUM_CS)-1:0] cs_idx
);
  localparam int IDX_W = $clog2(NUM_CS);

  logic              ctl_on_q;
  logic [IDX_W-1:0]  ctl_idx_q;
  logic              cpol_q, cpha_q, txl_q, rxl_q, wide_q;
  logic [1:0]        smp_sel_q;
  logic [WORD_W-1:0] dout_q;
  logic              cause_q;
  logic [31:0]       rd_mux;
  logic [31:0]       rdata_q;

  assign start   = bus_wr && (bus_addr == A_DOUT) && !busy;
  assign tx_word = bus_wdata[WORD_W-1:0];

  always_comb begin
    cfg        = '0;
    cfg.cpol   = cpol_q;
    cfg.cpha   = cpha_q;
    cfg.tx_lsb = txl_q;
    cfg.rx_lsb = rxl_q;
    cfg.wide   = wide_q;
    cfg.late   = (smp_sel_q == 2'd2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_on_q  <= 1'b0;
      ctl_idx_q <= '0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      txl_q     <= 1'b0;
      rxl_q     <= 1'b0;
      wide_q    <= 1'b0;
      smp_sel_q <= 2'd1;
      dout_q    <= '0;
      cause_q   <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CTRL: begin
            ctl_on_q  <= bus_wdata[0];
            ctl_idx_q <= bus_wdata[2 +: IDX_W];
          end
          A_CFG: begin
            wide_q <= bus_wdata[5];
            cpol_q <= bus_wdata[11];
            cpha_q <= bus_wdata[12];
            txl_q  <= bus_wdata[13];
            rxl_q  <= bus_wdata[14];
          end
          A_DOUT:   if (!busy) dout_q <= bus_wdata[WORD_W-1:0];
          A_CAUSE:  if (bus_wdata == 32'd0) cause_q <= 1'b0;
          A_TIMING: smp_sel_q <= bus_wdata[7:6];
          default: ;
        endcase
      end
      if (done) cause_q <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_mux[0]           = ctl_on_q;
        rd_mux[1]           = busy;
        rd_mux[2 +: IDX_W]  = ctl_idx_q;
      end
      A_CFG: begin
        rd_mux[5]  = wide_q;
        rd_mux[11] = cpol_q;
        rd_mux[12] = cpha_q;
        rd_mux[13] = txl_q;
        rd_mux[14] = rxl_q;
      end
      A_DOUT:   rd_mux[WORD_W-1:0] = dout_q;
      A_DIN:    rd_mux[WORD_W-1:0] = rx_word;
      A_CAUSE:  rd_mux[0] = cause_q;
      A_TIMING: rd_mux[7:6] = smp_sel_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign cause     = cause_q;
  assign cs_on     = ctl_on_q;
  assign cs_idx    = ctl_idx_q;
endmodule

// File: rtl/spi_word_engine.sv
module spi_word_engine
  import spi_word_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_en,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  input  xfer_cfg_t         cfg_live,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);
  localparam int HALF_W = WORD_W / 2;
  localparam int EDGE_W = $clog2(2 * WORD_W + 1);
  localparam int POS_W  = $clog2(WORD_W);

  xfer_cfg_t         snap_q;
  logic              busy_q, done_q, sck_q, mosi_q, cap1_q, cap2_q;
  logic [WORD_W-1:0] word_q, rx_q;
  logic [EDGE_W-1:0] edge_q, txi_q, rxn_q;
  logic [EDGE_W-1:0] nbits, nedges, rx_pos;
  logic              tick, leading, cap_edge, launch, smp, finish;

  function automatic logic pick(input logic [WORD_W-1:0] w, input logic [EDGE_W-1:0] i,
                                input logic lsb, input logic [EDGE_W-1:0] n);
    logic [EDGE_W-1:0] p;
    p = lsb ? i : (n - EDGE_W'(1) - i);
    return w[p[POS_W-1:0]];
  endfunction

  assign nbits    = snap_q.wide ? EDGE_W'(WORD_W) : EDGE_W'(HALF_W);
  assign nedges   = nbits << 1;
  assign tick     = busy_q && sck_en && (edge_q != nedges);
  assign leading  = !edge_q[0];
  assign cap_edge = tick && (snap_q.cpha ? !leading : leading);
  assign launch   = tick && !cap_edge && !(snap_q.cpha && edge_q == '0);
  assign smp      = snap_q.late ? cap2_q : cap1_q;
  assign finish   = busy_q && (edge_q == nedges) && (rxn_q == nbits);
  assign rx_pos   = snap_q.rx_lsb ? rxn_q : (nbits - EDGE_W'(1) - rxn_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      cap1_q <= 1'b0;
      cap2_q <= 1'b0;
      word_q <= '0;
      rx_q   <= '0;
      edge_q <= '0;
      txi_q  <= '0;
      rxn_q  <= '0;
    end else begin
      done_q <= 1'b0;
      cap1_q <= cap_edge;
      cap2_q <= cap1_q;
      if (!busy_q) begin
        sck_q <= cfg_live.cpol;
        if (start) begin
          busy_q <= 1'b1;
          snap_q <= cfg_live;
          word_q <= tx_word;
          edge_q <= '0;
          txi_q  <= '0;
          rxn_q  <= '0;
          rx_q   <= '0;
          mosi_q <= pick(tx_word, '0, cfg_live.tx_lsb,
                         cfg_live.wide ? EDGE_W'(WORD_W) : EDGE_W'(HALF_W));
        end
      end else begin
        if (tick) begin
          sck_q  <= ~sck_q;
          edge_q <= edge_q + EDGE_W'(1);
        end
        if (launch && (txi_q < nbits - EDGE_W'(1))) begin
          txi_q  <= txi_q + EDGE_W'(1);
          mosi_q <= pick(word_q, txi_q + EDGE_W'(1), snap_q.tx_lsb, nbits);
        end
        if (smp) begin
          rx_q[rx_pos[POS_W-1:0]] <= miso;
          rxn_q <= rxn_q + EDGE_W'(1);
        end
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
endmodule

// File: rtl/spi_word_csdec.sv
module spi_word_csdec #(
  parameter int NUM_CS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_on,
  input  logic [$clog2(NUM_CS)-1:0] cs_idx,
  output logic [NUM_CS-1:0]         cs_n
);
  localparam int IDX_W = $clog2(NUM_CS);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) cs_n[g] <= 1'b1;
      else     cs_n[g] <= !(cs_on && (cs_idx == IDX_W'(g)));
    end
  end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              sck_en,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int IDX_W = $clog2(NUM_CS);

  xfer_cfg_t         live_cfg;
  logic              xfer_busy, xfer_done, start, cause_flag, cfg_cpol, cs_on;
  logic [IDX_W-1:0]  cs_idx;
  logic [WORD_W-1:0] tx_word, rx_word;

  assign cfg_cpol = live_cfg.cpol;

  spi_word_regs #(.NUM_CS(NUM_CS), .WORD_W(WORD_W)) regs_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(xfer_busy), .done(xfer_done),
    .rx_word(rx_word), .start(start), .tx_word(tx_word), .cfg(live_cfg),
    .cause(cause_flag), .cs_on(cs_on), .cs_idx(cs_idx)
  );

  spi_word_engine #(.WORD_W(WORD_W)) eng_i (
    .clk(clk), .rst(rst), .sck_en(sck_en), .start(start), .tx_word(tx_word),
    .cfg_live(live_cfg), .miso(spi_miso), .busy(xfer_busy), .done(xfer_done),
    .rx_word(rx_word), .sck(spi_sck), .mosi(spi_mosi)
  );

  spi_word_csdec #(.NUM_CS(NUM_CS)) csdec_i (
    .clk(clk), .rst(rst), .cs_on(cs_on), .cs_idx(cs_idx), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sck_en,
  input logic              busy,
  input logic              cause,
  input logic              cfg_cpol,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic [NUM_CS-1:0] spi_cs_n
);
  AST_RESET_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (spi_cs_n == {NUM_CS{1'b1}})); // R1

  AST_ONE_CS_LOW: assert property (@(posedge clk) disable iff (rst)
    $countones(~spi_cs_n) <= 1); // R2

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> (spi_sck == $past(cfg_cpol))); // R3

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $stable(spi_sck)) |-> $stable(spi_mosi)); // R6

  AST_SCK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && !$stable(spi_sck)) |-> $past(sck_en)); // R6

  AST_DONE_SETS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |=> cause); // R7
endmodule

bind spi_word_master spi_word_master_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rst(rst), .sck_en(sck_en), .busy(xfer_busy), .cause(cause_flag),
  .cfg_cpol(cfg_cpol), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/spi_word_master_tb_top.sv
module spi_word_master_tb_top;
  localparam int CLK_P = 10;
  localparam logic [4:0] R_CTRL = 5'h00, R_CFG = 5'h04, R_DOUT = 5'h08,
                         R_DIN = 5'h0C, R_CAUSE = 5'h10, R_TIM = 5'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sck_en = 1'b0;
  logic        spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [7:0]  spi_cs_n;

  int total = 0, bad = 0;
  bit ended = 0;

  spi_word_master dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_en(sck_en),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // sck_en divider
  int en_div = 1;
  int divc = 0;
  always @(negedge clk) begin
    sck_en = (divc == 0);
    divc = (divc + 1 >= en_div) ? 0 : divc + 1;
  end

  // chip-select model: control register then output register
  logic       m_on = 1'b0;
  logic [2:0] m_idx = '0;
  logic [7:0] m_cs = 8'hFF;
  always @(posedge clk) begin
    if (rst) begin
      m_on <= 1'b0; m_idx <= '0; m_cs <= 8'hFF;
    end else begin
      if (bus_wr && bus_addr == R_CTRL) begin
        m_on <= bus_wdata[0]; m_idx <= bus_wdata[4:2];
      end
      m_cs <= m_on ? ~(8'd1 << m_idx) : 8'hFF;
    end
  end
  always @(negedge clk) if (!rst) chk(spi_cs_n == m_cs, "R2 cs per clock", {24'd0, spi_cs_n}, {24'd0, m_cs});

  // slave model: counts edges, records MOSI at capture edges, drives MISO
  bit          mon_cpha = 0;
  logic        prev_sck = 1'b0;
  int          ecount = 0, capi = 0;
  bit          off = 0;
  logic [15:0] mosi_seen = '0, miso_a = '0, miso_b = '0;
  always @(negedge clk) begin
    if (spi_sck !== prev_sck) begin
      prev_sck = spi_sck;
      if (mon_cpha ? (ecount % 2 == 1) : (ecount % 2 == 0)) begin
        if (capi < 16) begin
          mosi_seen[capi] = spi_mosi;
          spi_miso = miso_a[capi];
        end
        capi++;
        off = 1;
      end
      ecount++;
    end else if (off) begin
      if (capi >= 1 && capi <= 16) spi_miso = miso_b[capi-1];
      off = 0;
    end
  end

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic xfer(input logic [31:0] cfgw, input logic [1:0] tsel, input int div,
                      input logic [15:0] tx, input logic [15:0] a, input logic [15:0] b,
                      input bit poke, input string rq);
    logic [31:0] r;
    logic [15:0] exp_wire, exp_din, src;
    int n, guard;
    n = cfgw[5] ? 16 : 8;
    bus_write(R_CFG, cfgw);
    bus_write(R_TIM, {24'd0, tsel, 6'd0});
    bus_read(R_CFG, r);
    chk(r == (cfgw & 32'h7820), "R11 cfg readback", r, cfgw & 32'h7820);
    bus_read(R_TIM, r);
    chk(r == {24'd0, tsel, 6'd0}, "R11 timing readback", r, {24'd0, tsel, 6'd0});
    en_div = div;
    repeat (3) @(negedge clk);
    mon_cpha = cfgw[12]; prev_sck = spi_sck; ecount = 0; capi = 0; off = 0;
    mosi_seen = '0; miso_a = a; miso_b = b;
    bus_write(R_DOUT, {16'd0, tx});
    bus_read(R_CTRL, r);
    chk(r[1] == 1'b1, "R7 busy while shifting", r, 32'h2);
    if (poke) bus_write(R_DOUT, {16'd0, ~tx});
    guard = 0;
    do begin
      bus_read(R_CTRL, r);
      guard++;
    end while (r[1] && guard < 2000);
    exp_wire = '0; exp_din = '0;
    src = (tsel == 2'd2) ? b : a;
    for (int k = 0; k < n; k++) begin
      exp_wire[k] = cfgw[13] ? tx[k] : tx[n-1-k];
      if (cfgw[14]) exp_din[k] = src[k];
      else          exp_din[n-1-k] = src[k];
    end
    chk(mosi_seen == exp_wire, {rq, " mosi bits"}, {16'd0, mosi_seen}, {16'd0, exp_wire});
    chk(ecount == 2*n, "R6 edge count", ecount, 2*n);
    chk(spi_sck == cfgw[11], "R3 sck ends idle", {31'd0, spi_sck}, {31'd0, cfgw[11]});
    bus_read(R_DIN, r);
    chk(r == {16'd0, exp_din}, {rq, " data-in"}, r, {16'd0, exp_din});
    if (poke) begin
      bus_read(R_DOUT, r);
      chk(r == {16'd0, tx}, "R9 data-out kept", r, {16'd0, tx});
    end
    bus_read(R_CAUSE, r);
    chk(r == 32'd1, "R7 cause set", r, 32'd1);
    bus_write(R_CAUSE, 32'd5);
    bus_read(R_CAUSE, r);
    chk(r == 32'd1, "R8 nonzero write keeps cause", r, 32'd1);
    bus_write(R_CAUSE, 32'd0);
    bus_read(R_CAUSE, r);
    chk(r == 32'd0, "R8 zero write clears cause", r, 32'd0);
  endtask

  task automatic finish_up;
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_up();
  end

  initial begin
    logic [31:0] r;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(spi_cs_n == 8'hFF, "R1 cs after reset", {24'd0, spi_cs_n}, 32'hFF);
    bus_read(R_CAUSE, r);
    chk(r == 32'd0, "R1 cause after reset", r, 32'd0);
    bus_read(R_TIM, r);
    chk(r == 32'h40, "R1 timing after reset", r, 32'h40);
    bus_read(R_CTRL, r);
    chk(r == 32'd0, "R1 control after reset", r, 32'd0);
    // R2 each index
    for (int i = 0; i < 8; i++) begin
      bus_write(R_CTRL, (i << 2) | 1);
      repeat (2) @(negedge clk);
      chk(spi_cs_n == ~(8'd1 << i), "R2 selected cs low", {24'd0, spi_cs_n}, {24'd0, ~(8'd1 << i)});
      bus_read(R_CTRL, r);
      chk(r == ((i << 2) | 1), "R11 control readback", r, (i << 2) | 1);
    end
    bus_write(R_CTRL, (5 << 2));
    repeat (2) @(negedge clk);
    chk(spi_cs_n == 8'hFF, "R2 deassert", {24'd0, spi_cs_n}, 32'hFF);
    bus_write(R_CTRL, (3 << 2) | 1);
    // R3 modes, R4 orders, R5 sizes
    xfer(32'h0000, 2'd1, 1, 16'h00A5, 16'h003C, 16'h003C, 0, "R3 mode0 8b");
    xfer(32'h1820, 2'd1, 1, 16'h1234, 16'hBEEF, 16'hBEEF, 0, "R3 mode3 16b");
    xfer(32'h3000, 2'd1, 1, 16'h000E, 16'h0059, 16'h0059, 0, "R4 mode1 tx lsb");
    xfer(32'h4820, 2'd1, 1, 16'hC0DE, 16'h1357, 16'h1357, 0, "R4 mode2 rx lsb");
    xfer(32'h6020, 2'd1, 2, 16'h8001, 16'h00F1, 16'h00F1, 0, "R4 both lsb 16b");
    xfer(32'h0000, 2'd1, 1, 16'hFF3C, 16'h00C3, 16'h00C3, 0, "R5 8b ignores upper");
    xfer(32'h1000, 2'd1, 3, 16'h004B, 16'h00B4, 16'h00B4, 0, "R6 slow sck_en");
    // R9
    xfer(32'h0000, 2'd1, 1, 16'h0096, 16'h0011, 16'h0011, 1, "R9 write while busy");
    // R10 sample point
    xfer(32'h1820, 2'd1, 4, 16'h5A5A, 16'hA5C3, 16'h5A3C, 0, "R10 delay1");
    xfer(32'h1820, 2'd2, 4, 16'h5A5A, 16'hA5C3, 16'h5A3C, 0, "R10 delay2");
    xfer(32'h1820, 2'd3, 4, 16'h5A5A, 16'hA5C3, 16'h5A3C, 0, "R10 delay3 as 1");
    xfer(32'h0000, 2'd0, 4, 16'h0077, 16'h0069, 16'h0096, 0, "R10 delay0 as 1");
    finish_up();
  end
endmodule